// File: doc/BRIEF.md
# CPU Interrupt Enable and Mode Controller

This block is the interrupt front end of an 8-bit processor core. It keeps the two interrupt enable flip-flops, a two-bit interrupt mode register and an 8-bit vector-page register. The instruction decoder drives it with one-cycle strobes for enable, disable, return-from-NMI, mode select and vector-page load. The sequencer pulses `instr_done` at every instruction boundary. At that boundary the block decides whether a pending non-maskable or maskable request is taken.

When a request is taken, the block updates its enable flip-flops at the same clock edge. One cycle later it presents a single-cycle action descriptor. The descriptor says one of three things: execute the device-supplied opcode, call a fixed address, or fetch a 16-bit pointer from an address built from the vector page and the device byte. The second enable flip-flop is brought out so the core can copy it into the flags when the vector or refresh register is read. Running instructions and pushing the return address belong to the rest of the core.

Top module: `cpu_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `iff2_out` is 0, `take_valid` is 0, the mode is 0 and the vector page is 00h.
- R2: `ei_stb` sets both enable flip-flops and `di_stb` clears both; `iff2_out` shows the new value one cycle after the strobe. If both strobes arrive together, disable wins.
- R3: A maskable request (`int_req` high while `instr_done` pulses) is taken only while the first enable flip-flop is set. `take_valid` pulses in the cycle after that boundary.
- R4: Taking a maskable request clears both enable flip-flops.
- R5: Taking a non-maskable request gives `take_kind`=1 (call) with `take_addr`=0066h. It clears the first enable flip-flop and leaves `iff2_out` unchanged.
- R6: `retn_stb` copies the second enable flip-flop into the first, and the second keeps its value.
- R7: `nmi_req` is edge-sensitive. A 0-to-1 transition is remembered until the next boundary and taken there whatever the enable state. A level held high produces no further acceptance.
- R8: A remembered non-maskable request wins over a maskable request at the same boundary.
- R9: No maskable request is taken at the boundary that coincides with `ei_stb`, nor at the first boundary after an `ei_stb` that came before a boundary.
- R10: In mode 0, a maskable acceptance gives `take_kind`=0 (execute) and `take_op` equal to the `dev_byte` sampled at the boundary.
- R11: In mode 1, a maskable acceptance gives `take_kind`=1 with `take_addr`=0038h.
- R12: In mode 2, a maskable acceptance gives `take_kind`=2 (pointer fetch) with `take_addr` = {vector page, `dev_byte`}. The page is loaded through `vec_ld`/`vec_din`.
- R13: `im_stb` with `im_sel`=0, 1 or 2 selects that mode; `im_sel`=3 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| retn_stb | input | 1 | Return-from-NMI strobe |
| im_stb | input | 1 | Mode select strobe |
| im_sel | input | 2 | Requested mode (0, 1, 2; 3 ignored) |
| vec_ld | input | 1 | Vector page load strobe |
| vec_din | input | 8 | New vector page value |
| int_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, rising edge |
| instr_done | input | 1 | Instruction boundary pulse |
| dev_byte | input | 8 | Byte driven by the interrupting device |
| take_valid | output | 1 | One-cycle pulse: an action is issued |
| take_kind | output | 2 | 0 execute opcode, 1 call, 2 pointer fetch |
| take_addr | output | 16 | Call target or pointer address |
| take_op | output | 8 | Opcode to execute (kind 0), else 0 |
| iff2_out | output | 1 | Second enable flip-flop, for flag reporting |

## Verification
Every result here sits exactly one register away from its cause. `iff2_out` changes at the edge that samples a strobe or an acceptance. The action descriptor appears at the edge that samples `instr_done`. A remembered NMI edge needs one edge to be latched and can be taken no earlier than the following boundary. The bench drives every input on the falling edge and samples on the next falling edge, so each result is read half a period after the edge that made it. The scoreboard queue holds the expected descriptors in order. An unexpected pulse, a mismatch or an item left over at the end all count as failures.

// File: rtl/cpu_irq_pkg.sv
// Shared encodings for the interrupt controller.
// Assumes: mode and action codes are two bits wide and decoded by the core.
package cpu_irq_pkg;
    typedef enum logic [1:0] {
        MODE_OPCODE = 2'd0,
        MODE_FIXED  = 2'd1,
        MODE_TABLE  = 2'd2
    } irq_mode_e;

    typedef enum logic [1:0] {
        TAKE_EXEC = 2'd0,
        TAKE_CALL = 2'd1,
        TAKE_PTR  = 2'd2
    } take_kind_e;
endpackage

// File: rtl/irq_enable_ff.sv
// Holds the two interrupt enable flip-flops and the post-enable hold-off.
// Updates them once per cycle from acceptance events and decoder strobes.
// Assumes: an acceptance in a cycle overrides any strobe in the same cycle.
module irq_enable_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic ei_stb,
    input  logic di_stb,
    input  logic retn_stb,
    input  logic instr_done,
    input  logic take_nmi,
    input  logic take_int,
    output logic iff1,
    output logic iff2,
    output logic ei_block
);
    logic hold_q;

    // Enable flip-flop update: acceptance first, then retn, then di, then ei.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (take_nmi) begin
            iff1 <= 1'b0;
        end else if (take_int) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (retn_stb) begin
            iff1 <= iff2;
        end else if (di_stb) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else if (ei_stb) begin
            iff1 <= 1'b1;
            iff2 <= 1'b1;
        end
    end

    // Hold-off flag: armed by ei, consumed by the next boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b0;
        else if (instr_done)
            hold_q <= 1'b0;
        else if (ei_stb)
            hold_q <= 1'b1;
    end

    // Block maskable acceptance at the ei boundary or the one after it.
    always_comb ei_block = hold_q | ei_stb;
endmodule

// File: rtl/irq_nmi_edge.sv
// Detects a rising edge on the non-maskable request line and remembers it
// until it is taken. Assumes nmi_req is already synchronous to clk.
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    input  logic take_nmi,
    output logic nmi_pend
);
    logic nmi_q;
    logic nmi_rise;

    // Previous level of the request line, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_q <= 1'b0;
        else
            nmi_q <= nmi_req;
    end

    // A new rising edge.
    always_comb nmi_rise = nmi_req & ~nmi_q;

    // Pending flag: a new edge sets it, acceptance clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_pend <= 1'b0;
        else
            nmi_pend <= nmi_rise | (nmi_pend & ~take_nmi);
    end
endmodule

// File: rtl/irq_vector_gen.sv
// Keeps the interrupt mode and the vector page and turns an acceptance into a
// registered one-cycle action descriptor.
// Assumes: a mode or page change in the acceptance cycle applies afterwards.
module irq_vector_gen
    import cpu_irq_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIXED_ADDR = 'h38,
    parameter int unsigned NMI_ADDR   = 'h66
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                im_stb,
    input  logic [1:0]          im_sel,
    input  logic                vec_ld,
    input  logic [DATA_W-1:0]   vec_din,
    input  logic                take_nmi,
    input  logic                take_int,
    input  logic [DATA_W-1:0]   dev_byte,
    output logic                take_valid,
    output logic [1:0]          take_kind,
    output logic [2*DATA_W-1:0] take_addr,
    output logic [DATA_W-1:0]   take_op
);
    localparam int unsigned ADDR_W = 2 * DATA_W;

    irq_mode_e         mode_q;
    logic [DATA_W-1:0] page_q;
    take_kind_e        kind_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] op_d;

    // Mode register: code 3 is not a mode and is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_OPCODE;
        else if (im_stb && im_sel != 2'd3)
            mode_q <= irq_mode_e'(im_sel);
    end

    // Vector page register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (vec_ld)
            page_q <= vec_din;
    end

    // Descriptor selection from the source and the current mode.
    always_comb begin
        kind_d = TAKE_CALL;
        addr_d = ADDR_W'(NMI_ADDR);
        op_d   = '0;
        if (!take_nmi) begin
            unique case (mode_q)
                MODE_OPCODE: begin
                    kind_d = TAKE_EXEC;
                    addr_d = '0;
                    op_d   = dev_byte;
                end
                MODE_FIXED: begin
                    kind_d = TAKE_CALL;
                    addr_d = ADDR_W'(FIXED_ADDR);
                end
                default: begin
                    kind_d = TAKE_PTR;
                    addr_d = {page_q, dev_byte};
                end
            endcase
        end
    end

    // Registered descriptor, one pulse per acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid <= 1'b0;
            take_kind  <= 2'd0;
            take_addr  <= '0;
            take_op    <= '0;
        end else begin
            take_valid <= take_nmi | take_int;
            if (take_nmi | take_int) begin
                take_kind <= kind_d;
                take_addr <= addr_d;
                take_op   <= op_d;
            end
        end
    end
endmodule

// File: rtl/cpu_irq_ctrl.sv
// Top of the interrupt controller: arbitrates between a remembered
// non-maskable edge and a maskable level at each instruction boundary.
// Assumes: all inputs are synchronous to clk, strobes are one cycle wide.
module cpu_irq_ctrl #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIXED_ADDR = 'h38,
    parameter int unsigned NMI_ADDR   = 'h66
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ei_stb,
    input  logic                di_stb,
    input  logic                retn_stb,
    input  logic                im_stb,
    input  logic [1:0]          im_sel,
    input  logic                vec_ld,
    input  logic [DATA_W-1:0]   vec_din,
    input  logic                int_req,
    input  logic                nmi_req,
    input  logic                instr_done,
    input  logic [DATA_W-1:0]   dev_byte,
    output logic                take_valid,
    output logic [1:0]          take_kind,
    output logic [2*DATA_W-1:0] take_addr,
    output logic [DATA_W-1:0]   take_op,
    output logic                iff2_out
);
    logic iff1;
    logic iff2;
    logic ei_block;
    logic nmi_pend;
    logic take_nmi;
    logic take_int;

    // Boundary arbitration: the remembered edge wins over the level.
    always_comb begin
        take_nmi = instr_done & nmi_pend;
        take_int = instr_done & ~nmi_pend & int_req & iff1 & ~ei_block;
    end

    always_comb iff2_out = iff2;

    irq_enable_ff u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .ei_stb     (ei_stb),
        .di_stb     (di_stb),
        .retn_stb   (retn_stb),
        .instr_done (instr_done),
        .take_nmi   (take_nmi),
        .take_int   (take_int),
        .iff1       (iff1),
        .iff2       (iff2),
        .ei_block   (ei_block)
    );

    irq_nmi_edge u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .take_nmi (take_nmi),
        .nmi_pend (nmi_pend)
    );

    irq_vector_gen #(
        .DATA_W     (DATA_W),
        .FIXED_ADDR (FIXED_ADDR),
        .NMI_ADDR   (NMI_ADDR)
    ) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .im_stb     (im_stb),
        .im_sel     (im_sel),
        .vec_ld     (vec_ld),
        .vec_din    (vec_din),
        .take_nmi   (take_nmi),
        .take_int   (take_int),
        .dev_byte   (dev_byte),
        .take_valid (take_valid),
        .take_kind  (take_kind),
        .take_addr  (take_addr),
        .take_op    (take_op)
    );
endmodule

// File: rtl/cpu_irq_ctrl_checker.sv
// Temporal checks on the interrupt controller, attached by bind.
module cpu_irq_ctrl_checker #(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned FIXED_ADDR = 'h38,
    parameter int unsigned NMI_ADDR   = 'h66
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ei_stb,
    input logic                di_stb,
    input logic                retn_stb,
    input logic                instr_done,
    input logic                take_valid,
    input logic [1:0]          take_kind,
    input logic [2*DATA_W-1:0] take_addr,
    input logic                iff1,
    input logic                iff2_out
);
    localparam int unsigned ADDR_W = 2 * DATA_W;

    logic nmi_take;
    always_comb nmi_take = take_valid && take_kind == 2'd1 &&
                           take_addr == ADDR_W'(NMI_ADDR);

    assert_ei_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_stb && !di_stb && !retn_stb && !instr_done) |=> iff2_out);

    assert_di_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (di_stb && !retn_stb && !instr_done) |=> !iff2_out);

    assert_int_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && !nmi_take) |-> $past(iff1));

    assert_int_clears_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && !nmi_take) |-> (!iff2_out && !iff1));

    assert_nmi_keeps_iff2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_take |-> (iff2_out == $past(iff2_out) && !iff1));

    assert_retn_restores_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (retn_stb && !instr_done) |=> (iff1 == $past(iff2_out) && $stable(iff2_out)));

    assert_ei_holdoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_stb && instr_done) |=> !(take_valid && !nmi_take));

    assert_call_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_kind == 2'd1) |->
        (take_addr == ADDR_W'(FIXED_ADDR) || take_addr == ADDR_W'(NMI_ADDR)));

    assert_kind_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> take_kind != 2'd3);
endmodule

bind cpu_irq_ctrl cpu_irq_ctrl_checker #(
    .DATA_W     (DATA_W),
    .FIXED_ADDR (FIXED_ADDR),
    .NMI_ADDR   (NMI_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ei_stb     (ei_stb),
    .di_stb     (di_stb),
    .retn_stb   (retn_stb),
    .instr_done (instr_done),
    .take_valid (take_valid),
    .take_kind  (take_kind),
    .take_addr  (take_addr),
    .iff1       (iff1),
    .iff2_out   (iff2_out)
);

// File: tb/cpu_irq_ctrl_bench.sv
// Scoreboard bench: tasks push expected descriptors, a monitor pops them.
module cpu_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ei_stb = 1'b0, di_stb = 1'b0, retn_stb = 1'b0;
    logic        im_stb = 1'b0, vec_ld = 1'b0;
    logic [1:0]  im_sel = 2'd0;
    logic [7:0]  vec_din = 8'h00;
    logic        int_req = 1'b0, nmi_req = 1'b0, instr_done = 1'b0;
    logic [7:0]  dev_byte = 8'hFF;
    logic        take_valid;
    logic [1:0]  take_kind;
    logic [15:0] take_addr;
    logic [7:0]  take_op;
    logic        iff2_out;

    int total = 0;
    int bad = 0;
    logic [25:0] exp_q[$];
    string       exp_tag[$];

    always #4 clk = ~clk;

    cpu_irq_ctrl u_cpu_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ei_stb(ei_stb), .di_stb(di_stb),
        .retn_stb(retn_stb), .im_stb(im_stb), .im_sel(im_sel),
        .vec_ld(vec_ld), .vec_din(vec_din), .int_req(int_req),
        .nmi_req(nmi_req), .instr_done(instr_done), .dev_byte(dev_byte),
        .take_valid(take_valid), .take_kind(take_kind),
        .take_addr(take_addr), .take_op(take_op), .iff2_out(iff2_out)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(input logic [1:0] k, input logic [15:0] a,
                        input logic [7:0] o, input string tag);
        exp_q.push_back({k, a, o});
        exp_tag.push_back(tag);
    endtask

    task automatic chk_iff2(input logic exp, input string tag);
        total++;
        if (iff2_out !== exp) begin
            bad++;
            $display("FAIL %s: iff2_out actual=%0b expected=%0b", tag, iff2_out, exp);
        end
    endtask

    task automatic boundary();
        instr_done = 1'b1; step(); instr_done = 1'b0;
    endtask

    task automatic do_ei();
        ei_stb = 1'b1; step(); ei_stb = 1'b0;
    endtask

    task automatic do_di();
        di_stb = 1'b1; step(); di_stb = 1'b0;
    endtask

    task automatic do_retn();
        retn_stb = 1'b1; step(); retn_stb = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        im_sel = m; im_stb = 1'b1; step(); im_stb = 1'b0;
    endtask

    task automatic nmi_pulse();
        nmi_req = 1'b1; step(); step(); nmi_req = 1'b0; step();
    endtask

    // Monitor: every descriptor pulse must match the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && take_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected take: actual kind=%0d addr=%h op=%h expected none",
                         take_kind, take_addr, take_op);
            end else begin
                logic [25:0] e;
                string t;
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                if ({take_kind, take_addr, take_op} !== e) begin
                    bad++;
                    $display("FAIL %s: actual kind=%0d addr=%h op=%h expected kind=%0d addr=%h op=%h",
                             t, take_kind, take_addr, take_op, e[25:24], e[23:8], e[7:0]);
                end
            end
        end
    end

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        // R1: reset state
        total++;
        if (take_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1: take_valid actual=%0b expected=0", take_valid);
        end
        chk_iff2(1'b0, "R1");
        rst_n = 1'b1;
        step();

        // R3: request ignored while disabled
        int_req = 1'b1;
        boundary();
        // R9: ei coinciding with a boundary blocks that boundary
        ei_stb = 1'b1; instr_done = 1'b1; step(); ei_stb = 1'b0; instr_done = 1'b0;
        chk_iff2(1'b1, "R2 ei");
        // R10 and R1 mode 0 after reset: execute device byte
        dev_byte = 8'hFF;
        push(2'd0, 16'h0000, 8'hFF, "R10");
        boundary();
        chk_iff2(1'b0, "R4");
        boundary();  // R3: disabled again, no take

        // R11 with R9: early ei holds off the next boundary
        set_mode(2'd1);
        do_ei();
        boundary();
        push(2'd1, 16'h0038, 8'h00, "R11");
        boundary();
        // R9 while iff1 already set
        do_ei();
        int_req = 1'b0; boundary(); int_req = 1'b1;
        ei_stb = 1'b1; instr_done = 1'b1; step(); ei_stb = 1'b0; instr_done = 1'b0;
        push(2'd1, 16'h0038, 8'h00, "R9");
        boundary();

        // R12: page still 00h from reset (R1)
        set_mode(2'd2);
        do_ei(); boundary();
        dev_byte = 8'h3C;
        push(2'd2, 16'h003C, 8'h00, "R12 R1 page");
        boundary();
        vec_din = 8'hA5; vec_ld = 1'b1; step(); vec_ld = 1'b0;
        do_ei(); boundary();
        dev_byte = 8'h7E;
        push(2'd2, 16'hA57E, 8'h00, "R12");
        boundary();

        // R13: code 3 keeps mode 2
        set_mode(2'd3);
        do_ei(); boundary();
        push(2'd2, 16'hA57E, 8'h00, "R13");
        boundary();

        // R5, R7: NMI with iff2 set
        int_req = 1'b0;
        do_ei();
        chk_iff2(1'b1, "R2 ei again");
        nmi_req = 1'b1; step();
        push(2'd1, 16'h0066, 8'h00, "R5");
        boundary();
        chk_iff2(1'b1, "R5 iff2 kept");
        boundary();  // R7: held level, no second take
        int_req = 1'b1;
        boundary();  // R5: iff1 cleared, no maskable take
        int_req = 1'b0;
        nmi_req = 1'b0;
        do_retn();
        chk_iff2(1'b1, "R6 iff2 kept");
        int_req = 1'b1;
        push(2'd2, 16'hA57E, 8'h00, "R6 restored");
        boundary();
        chk_iff2(1'b0, "R4 again");

        // R7 and R6 with iff2 clear
        int_req = 1'b0;
        nmi_pulse();
        step(); step();
        push(2'd1, 16'h0066, 8'h00, "R7 remembered");
        boundary();
        chk_iff2(1'b0, "R5 iff2 clear kept");
        do_retn();
        int_req = 1'b1;
        boundary();  // R6: iff1 restored to 0, no take

        // R8: NMI wins over maskable at one boundary
        do_ei(); int_req = 1'b0; boundary(); int_req = 1'b1;
        nmi_req = 1'b1; step();
        push(2'd1, 16'h0066, 8'h00, "R8");
        boundary();
        boundary();  // R8: maskable not taken with iff1 cleared
        nmi_req = 1'b0;
        do_retn();
        push(2'd2, 16'hA57E, 8'h00, "R8 after retn");
        boundary();

        // R2: disable
        int_req = 1'b0;
        do_ei();
        do_di();
        chk_iff2(1'b0, "R2 di");
        int_req = 1'b1;
        boundary();  // R2: no take after di
        // R2: ei with di together, disable wins
        ei_stb = 1'b1; di_stb = 1'b1; step(); ei_stb = 1'b0; di_stb = 1'b0;
        chk_iff2(1'b0, "R2 both");
        boundary();
        step(); step();

        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R3: pending expected takes actual=%0d expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule